// File: doc/BRIEF.md
# CPU Cluster Power and Boot Control Registers

This block is a register file for a cluster of CPUs. It sits on a simple 32-bit word-only register bus. For each CPU it holds a 64-bit boot address, written as a low word and a high word, and drives that address out as a 64-bit value. It also holds a power-down request word.

Each request bit is combined with the CPU's sampled wait-for-interrupt input. The result tells a power manager which CPUs are idle and may be switched off. A per-CPU power-state output follows each request bit, and it moves only when that bit is written with a different value. A one-bit fault status, with a mask that software changes through separate enable and disable registers, drives a single interrupt line.

The map is in word offsets. Offset 0 is error control, 1 is fault status, 2 is the fault mask, 3 is the mask-enable register and 4 is the mask-disable register. Offsets 5 and 6 are two configuration words. Offsets 7 to 14 are the boot words, low then high for CPU 0, 1, 2 and 3 (CPU i low at 7+2i, high at 8+2i). Offset 15 is coherency control, 16 is snoop control, 17 is the power-down request word and 18 is the power status word.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After reset, registers read as follows: each boot low word is 0xFFFF0000 and each boot high word is 0. Configuration word 0 is 0x00000F0F and coherency control is 0x000F000F. The mask reads 1 and every other register reads 0. After reset `irq_o`, `wfi_req_o` and `pwr_stat_o` are 0.
- R2: `boot_addr[64*i +: 64]` equals {high word, low word} of CPU i. It shows a written value in the cycle after the write.
- R3: A write takes effect only when `wr_strb` is 4'hF. Any other strobe leaves every register unchanged.
- R4: `wfi_in` is registered once. `wfi_req_o[i]` is request bit i (offset 17, bit i) AND the registered `wfi_in[i]`, so it follows a change of either one with one cycle of latency.
- R5: `pwr_stat_o[i]` is updated by a write to offset 17 only when the written bit i differs from the stored request bit, and it takes the new bit value. Rewriting the same value leaves it unchanged.
- R6: Fault status bit 0 is set by a high `fault_pulse` and cleared by writing 1 to bit 0 of offset 1. A set in the same cycle wins, and writing 0 has no effect.
- R7: The mask (offset 2, bit 0) ignores direct writes. Writing 1 in bit 0 to offset 3 clears it, and writing 1 in bit 0 to offset 4 sets it. Offsets 3 and 4 read as 0.
- R8: `irq_o` is high exactly when the fault status is 1 and the mask is 0.
- R9: At offset 18, bits 17:16 and 3:0 are read-only zero. All other bits are read/write.
- R10: Error control, both configuration words, coherency control, snoop control and the request word read back the full written word. Offsets above 18 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_strb | input | 4 | Byte enables; only 4'hF writes |
| addr | input | 5 | Word offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| fault_pulse | input | 1 | Sets fault status bit 0 |
| wfi_in | input | 4 | Per-CPU wait-for-interrupt indication |
| wfi_req_o | output | 4 | Per-CPU idle-and-request toward the power manager |
| pwr_stat_o | output | 4 | Per-CPU power-state indication |
| irq_o | output | 1 | Fault interrupt |
| boot_addr | output | 256 | Per-CPU 64-bit boot address, CPU i at bits 64i+63:64i |

## Verification
Several behaviours are checked by assertions on every cycle:
- Partial-strobe writes leave the boot addresses untouched.
- The power-state outputs hold still unless the request word is written.
- The mask moves only under an enable or disable write.
- A clear without a concurrent set drops the status.
- A high `wfi_req_o` bit always traces back to a high `wfi_in` one cycle earlier.

The directed scenarios show the things no single-cycle property captures:
- the reset values,
- the exact 64-bit boot address composition,
- the read-only bit pattern of the power status word,
- set-over-clear priority,
- readback of the plain registers.

// File: rtl/cluster_pwr_ctrl.sv
module cluster_pwr_ctrl #(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 5,
  parameter logic [31:0] BOOT_LO_RST = 32'hFFFF_0000,
  parameter logic [31:0] CFG0_RST    = 32'h0000_0F0F,
  parameter logic [31:0] COH_RST     = 32'h000F_000F,
  parameter logic [31:0] PST_RO      = 32'h0003_000F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           wr_strb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic                 fault_pulse,
  input  logic [NCPU-1:0]      wfi_in,
  output logic [NCPU-1:0]      wfi_req_o,
  output logic [NCPU-1:0]      pwr_stat_o,
  output logic                 irq_o,
  output logic [NCPU*64-1:0]   boot_addr
);

  localparam int VEC_BASE = 7;
  localparam int COH_OFF  = VEC_BASE + 2*NCPU;
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_COH  = ADDR_W'(COH_OFF);
  localparam logic [ADDR_W-1:0] A_SNP  = ADDR_W'(COH_OFF + 1);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(COH_OFF + 2);
  localparam logic [ADDR_W-1:0] A_PST  = ADDR_W'(COH_OFF + 3);

  logic        wr_ok;
  logic [31:0] err_q, cfg0_q, cfg1_q, coh_q, snp_q, pwr_q, pst_q;
  logic        stat_q, mask_q;
  logic [NCPU-1:0] wfi_q, stat_out_q;
  logic [31:0] vec_lo [NCPU];
  logic [31:0] vec_hi [NCPU];

  assign wr_ok = wr_en && (wr_strb == 4'hF);

  // plain read/write words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      cfg0_q <= CFG0_RST;
      cfg1_q <= '0;
      coh_q  <= COH_RST;
      snp_q  <= '0;
      pwr_q  <= '0;
      pst_q  <= '0;
    end else if (wr_ok) begin
      case (addr)
        A_ERR:   err_q  <= wdata;
        A_CFG0:  cfg0_q <= wdata;
        A_CFG1:  cfg1_q <= wdata;
        A_COH:   coh_q  <= wdata;
        A_SNP:   snp_q  <= wdata;
        A_PWR:   pwr_q  <= wdata;
        A_PST:   pst_q  <= wdata & ~PST_RO;
        default: ;
      endcase
    end
  end

  // fault status and mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (fault_pulse)
        stat_q <= 1'b1;
      else if (wr_ok && addr == A_STAT && wdata[0])
        stat_q <= 1'b0;
      if (wr_ok && addr == A_EN && wdata[0])
        mask_q <= 1'b0;
      else if (wr_ok && addr == A_DIS && wdata[0])
        mask_q <= 1'b1;
    end
  end

  assign irq_o = stat_q & ~mask_q;

  // per-CPU boot words, idle sampling and power-state
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(VEC_BASE + 2*i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(VEC_BASE + 2*i + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_lo[i] <= BOOT_LO_RST;
        vec_hi[i] <= '0;
      end else if (wr_ok) begin
        if (addr == A_LO) vec_lo[i] <= wdata;
        if (addr == A_HI) vec_hi[i] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wfi_q[i]      <= 1'b0;
        stat_out_q[i] <= 1'b0;
      end else begin
        wfi_q[i] <= wfi_in[i];
        if (wr_ok && addr == A_PWR && (wdata[i] != pwr_q[i]))
          stat_out_q[i] <= wdata[i];
      end
    end

    assign boot_addr[64*i +: 64] = {vec_hi[i], vec_lo[i]};
    assign wfi_req_o[i]          = pwr_q[i] & wfi_q[i];

    p_wfi_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wfi_req_o[i] |-> $past(wfi_in[i]));
  end

  assign pwr_stat_o = stat_out_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_ERR:   rdata = err_q;
      A_STAT:  rdata = {31'b0, stat_q};
      A_MASK:  rdata = {31'b0, mask_q};
      A_CFG0:  rdata = cfg0_q;
      A_CFG1:  rdata = cfg1_q;
      A_COH:   rdata = coh_q;
      A_SNP:   rdata = snp_q;
      A_PWR:   rdata = pwr_q;
      A_PST:   rdata = pst_q;
      default: rdata = '0;
    endcase
    for (int k = 0; k < NCPU; k++) begin
      if (addr == ADDR_W'(VEC_BASE + 2*k))     rdata = vec_lo[k];
      if (addr == ADDR_W'(VEC_BASE + 2*k + 1)) rdata = vec_hi[k];
    end
  end

  p_partial_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_strb != 4'hF) |=> $stable(boot_addr));

  p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && addr == A_PWR) |=> $stable(pwr_stat_o));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && (addr == A_EN || addr == A_DIS)) |=> $stable(mask_q));

  p_mask_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_EN && wdata[0]) |=> !mask_q);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_STAT && wdata[0] && !fault_pulse) |=> !irq_o);

endmodule

// File: tb/test_cluster_pwr_ctrl.sv
module test_cluster_pwr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = 4'h0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fault_pulse = 1'b0;
  logic [3:0]  wfi_in = '0;
  logic [3:0]  wfi_req_o, pwr_stat_o;
  logic        irq_o;
  logic [255:0] boot_addr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cluster_pwr_ctrl i_cluster_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fault_pulse(fault_pulse), .wfi_in(wfi_in),
    .wfi_req_o(wfi_req_o), .pwr_stat_o(pwr_stat_o), .irq_o(irq_o),
    .boot_addr(boot_addr));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    addr = a; wdata = d; wr_strb = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_fault();
    @(negedge clk); fault_pulse = 1'b1;
    @(negedge clk); fault_pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'd7, d);  check("R1 boot lo", d, 32'hFFFF0000);
    rd(5'd14, d); check("R1 boot hi", d, 0);
    rd(5'd5, d);  check("R1 cfg0", d, 32'h0F0F);
    rd(5'd6, d);  check("R1 cfg1", d, 0);
    rd(5'd15, d); check("R1 coh", d, 32'h000F000F);
    rd(5'd2, d);  check("R1 mask", d, 1);
    rd(5'd1, d);  check("R1 status", d, 0);
    check("R1 outputs", {irq_o, wfi_req_o, pwr_stat_o}, 0);
    for (int i = 0; i < 4; i++)
      check("R1 boot_addr", boot_addr[64*i +: 64], 64'h0000_0000_FFFF_0000);
  endtask

  task automatic t_vectors();
    wr(5'd11, 32'h1234_5600);
    wr(5'd12, 32'h0000_00A5);
    check("R2 cpu2 addr", boot_addr[128 +: 64], 64'h0000_00A5_1234_5600);
    check("R2 cpu0 untouched", boot_addr[0 +: 64], 64'h0000_0000_FFFF_0000);
    wr(5'd8, 32'hDEAD_BEEF);
    check("R2 cpu0 hi", boot_addr[0 +: 64], 64'hDEAD_BEEF_FFFF_0000);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    wr(5'd6, 32'h5555_AAAA, 4'h3);
    rd(5'd6, d); check("R3 partial cfg1", d, 0);
    wr(5'd13, 32'h1111_2222, 4'h7);
    check("R3 partial boot", boot_addr[192 +: 64], 64'h0000_0000_FFFF_0000);
  endtask

  task automatic t_wfi();
    @(negedge clk) wfi_in = 4'hF;
    @(negedge clk);
    check("R4 no request", wfi_req_o, 4'h0);
    wr(5'd17, 32'h5);
    check("R4 req and wfi", wfi_req_o, 4'h5);
    @(negedge clk) wfi_in = 4'h4;
    @(negedge clk);
    check("R4 wfi drop", wfi_req_o, 4'h4);
  endtask

  task automatic t_pstat();
    check("R5 after write", pwr_stat_o, 4'h5);
    wr(5'd17, 32'h5);
    check("R5 same value", pwr_stat_o, 4'h5);
    wr(5'd17, 32'h3);
    check("R5 changed", pwr_stat_o, 4'h3);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse_fault();
    rd(5'd1, d); check("R6 set", d, 1);
    check("R8 masked", irq_o, 0);
    wr(5'd2, 32'h0);
    rd(5'd2, d); check("R7 mask ro", d, 1);
    wr(5'd3, 32'h1);
    rd(5'd2, d); check("R7 enable", d, 0);
    check("R8 irq on", irq_o, 1);
    rd(5'd3, d); check("R7 enable reads 0", d, 0);
    wr(5'd4, 32'h1);
    check("R8 irq off", irq_o, 0);
    wr(5'd3, 32'h1);
    wr(5'd1, 32'h0);
    check("R6 write 0", irq_o, 1);
    @(negedge clk);
    addr = 5'd1; wdata = 32'h1; wr_strb = 4'hF; wr_en = 1'b1; fault_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; fault_pulse = 1'b0;
    check("R6 set wins", irq_o, 1);
    wr(5'd1, 32'h1);
    rd(5'd1, d); check("R6 cleared", d, 0);
    check("R8 irq after clear", irq_o, 0);
  endtask

  task automatic t_pst();
    logic [31:0] d;
    wr(5'd18, 32'hFFFF_FFFF);
    rd(5'd18, d); check("R9 ro bits", d, 32'hFFFC_FFF0);
  endtask

  task automatic t_rw();
    logic [31:0] d;
    wr(5'd0, 32'hCAFE_0001);  rd(5'd0, d);  check("R10 err", d, 32'hCAFE_0001);
    wr(5'd16, 32'h0BAD_F00D); rd(5'd16, d); check("R10 snoop", d, 32'h0BAD_F00D);
    wr(5'd15, 32'h1357_9BDF); rd(5'd15, d); check("R10 coh", d, 32'h1357_9BDF);
    wr(5'd17, 32'hA000_0003); rd(5'd17, d); check("R10 req word", d, 32'hA000_0003);
    wr(5'd25, 32'hFFFF_FFFF); rd(5'd25, d); check("R10 unmapped", d, 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_vectors();
    t_partial();
    t_wfi();
    t_pstat();
    t_irq();
    t_pst();
    t_rw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule